// File: doc/BRIEF.md
# Compressed Sample Block Decoder

This block turns a stream of 9-byte compressed audio blocks into signed 16-bit PCM samples. A start pulse picks a directory page and an entry index. The decoder reads the 4-byte directory entry to learn where the sound begins and where it loops. It then walks the blocks one byte at a time through a request/valid byte-fetch port and hands out one sample per handshake on a ready/valid output.

Each block opens with a header byte that selects a left shift and one of four fixed second-order predictors. Eight data bytes follow, each holding two four-bit codes. A two-sample history carries the predictor across block boundaries. A header flag marks the last block of a sound. When that block ends, the decoder either jumps back to the loop address or stops. When it stops, it holds out silence until it is started again. A sticky flag reports that the final block has been reached.

Top module: `adpcm_blk_dec`

## Requirements
- R1: After a start pulse with page P and index N, the decoder reads four bytes at addresses P*256+4*N+0..3. These are the start address low and high bytes, then the loop address low and high bytes. It then reads the first header at the start address.
- R2: A block is a header byte followed by 8 data bytes. In the header, bits 7-4 give the shift, bits 3-2 the filter, bit 1 the loop flag and bit 0 the end flag. Each data byte gives two samples, the high nibble first. A nibble is a signed two's-complement value from -8 to 7.
- R3: A sample is the nibble shifted left by the shift value, plus floor((c1*old1 + c2*old2)/64). Here old1 is the previous output and old2 is the one before it. The sum is clamped to the range -32768..32767.
- R4: The predictor weights (c1, c2) are (0,0) for filter 0, (60,0) for filter 1, (122,-60) for filter 2 and (115,-52) for filter 3.
- R5: The two-sample history continues across block boundaries and is set to zero by a start pulse, including a start pulse in the middle of a sound.
- R6: A block without the end flag is followed by the next block at the following address.
- R7: When the last sample of a block with both the end and loop flags is accepted, end_hit is set and decoding continues with the header at the loop address.
- R8: When the last sample of a block with the end flag but no loop flag is accepted, end_hit is set. From then on the output is valid with value zero and no byte is fetched until the next start.
- R9: While smp_valid is high and smp_ready is low, smp_valid stays high and smp_data holds its value.
- R10: While mem_req is high and mem_valid is low, mem_req stays high and mem_addr holds its value.
- R11: Out of reset, mem_req, smp_valid and end_hit are low.
- R12: A start pulse clears end_hit on the next cycle and restarts at the directory read, whatever the decoder was doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that starts a sound |
| dir_page | input | 8 | Directory page, base address = dir_page*256 |
| src_idx | input | 8 | Directory entry index |
| mem_req | output | 1 | Byte fetch request |
| mem_addr | output | 16 | Byte fetch address |
| mem_valid | input | 1 | Fetched byte is present this cycle |
| mem_data | input | 8 | Fetched byte |
| smp_valid | output | 1 | Output sample available |
| smp_ready | input | 1 | Consumer takes the sample |
| smp_data | output | 16 | Signed PCM sample |
| end_hit | output | 1 | Sticky flag: a final block has been completed |

## Verification
The block has no parameters, so the bench builds its single 16-bit-address, 4-bit-code configuration. That configuration is small enough to sweep every pairing of the 16 shift values with the 4 filters. Every one of the 16 nibble codes appears inside each pairing, which reaches both clamp limits and the floor rounding of negative predictor terms. Separate sounds cover a self-loop, a one-block stop into silence and a restart partway through a block. Fetch latency and consumer stalls vary from sample to sample.

// File: rtl/adpcm_blk_dec.sv
module adpcm_blk_dec (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  dir_page,
  input  logic [7:0]  src_idx,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  input  logic        mem_valid,
  input  logic [7:0]  mem_data,
  output logic        smp_valid,
  input  logic        smp_ready,
  output logic [15:0] smp_data,
  output logic        end_hit
);
  typedef enum logic [2:0] {S_IDLE, S_DIR, S_HDR, S_DATA, S_HI, S_LO, S_END} st_t;

  st_t                state;
  logic [2:0]         cnt;
  logic [15:0]        ptr, loop_addr;
  logic [7:0]         hdr, dbyte;
  logic signed [15:0] p1, p2;

  logic [3:0]         nib;
  logic signed [23:0] base, x1, x2, acc, raw;
  logic signed [15:0] sample;

  assign nib  = (state == S_LO) ? dbyte[3:0] : dbyte[7:4];
  assign base = {{20{nib[3]}}, nib} <<< hdr[7:4];
  assign x1   = {{8{p1[15]}}, p1};
  assign x2   = {{8{p2[15]}}, p2};

  always_comb begin
    case (hdr[3:2])
      2'd0: acc = '0;
      2'd1: acc = (x1 <<< 6) - (x1 <<< 2);
      2'd2: acc = (x1 <<< 7) - (x1 <<< 2) - (x1 <<< 1) - ((x2 <<< 6) - (x2 <<< 2));
      default: acc = (x1 <<< 7) - (x1 <<< 3) - (x1 <<< 2) - x1
                     - ((x2 <<< 5) + (x2 <<< 4) + (x2 <<< 2));
    endcase
  end

  assign raw = base + (acc >>> 6);

  always_comb begin
    if (raw > 24'sd32767)        sample = 16'sh7FFF;
    else if (raw < -24'sd32768)  sample = 16'sh8000;
    else                         sample = raw[15:0];
  end

  assign mem_req   = (state == S_DIR) || (state == S_HDR) || (state == S_DATA);
  assign mem_addr  = (state == S_DIR) ? {dir_page, 8'h00} + {6'd0, src_idx, 2'b00} + {14'd0, cnt[1:0]}
                                      : ptr;
  assign smp_valid = (state == S_HI) || (state == S_LO) || (state == S_END);
  assign smp_data  = (state == S_END) ? 16'd0 : sample;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      ptr       <= '0;
      loop_addr <= '0;
      hdr       <= '0;
      dbyte     <= '0;
      p1        <= '0;
      p2        <= '0;
      end_hit   <= 1'b0;
    end else if (start) begin
      state   <= S_DIR;
      cnt     <= '0;
      p1      <= '0;
      p2      <= '0;
      end_hit <= 1'b0;
    end else begin
      case (state)
        S_DIR: if (mem_valid) begin
          case (cnt[1:0])
            2'd0: ptr[7:0]        <= mem_data;
            2'd1: ptr[15:8]       <= mem_data;
            2'd2: loop_addr[7:0]  <= mem_data;
            default: begin
              loop_addr[15:8] <= mem_data;
              state           <= S_HDR;
            end
          endcase
          cnt <= cnt + 3'd1;
        end
        S_HDR: if (mem_valid) begin
          hdr   <= mem_data;
          ptr   <= ptr + 16'd1;
          cnt   <= '0;
          state <= S_DATA;
        end
        S_DATA: if (mem_valid) begin
          dbyte <= mem_data;
          ptr   <= ptr + 16'd1;
          state <= S_HI;
        end
        S_HI: if (smp_ready) begin
          p2    <= p1;
          p1    <= sample;
          state <= S_LO;
        end
        S_LO: if (smp_ready) begin
          p2  <= p1;
          p1  <= sample;
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            if (hdr[0]) begin
              end_hit <= 1'b1;
              if (hdr[1]) begin
                ptr   <= loop_addr;
                state <= S_HDR;
              end else begin
                state <= S_END;
              end
            end else begin
              state <= S_HDR;
            end
          end else begin
            state <= S_DATA;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/adpcm_blk_dec_chk.sv
module adpcm_blk_dec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        mem_req,
  input logic [15:0] mem_addr,
  input logic        mem_valid,
  input logic        smp_valid,
  input logic        smp_ready,
  input logic [15:0] smp_data,
  input logic        end_hit
);
  p_fetch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid && !start |=> mem_req && $stable(mem_addr));

  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready && !start |=> smp_valid && $stable(smp_data));

  p_start_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> mem_req && !end_hit && !smp_valid);

  p_end_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    end_hit && !start |=> end_hit);

  p_end_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_hit) |-> $past(smp_valid && smp_ready));

  p_fetch_or_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && smp_valid));
endmodule

bind adpcm_blk_dec adpcm_blk_dec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_valid(mem_valid), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .smp_data(smp_data), .end_hit(end_hit)
);

// File: tb/sim_adpcm_blk_dec.sv
module sim_adpcm_blk_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  dir_page = 8'h01;
  logic [7:0]  src_idx = 8'h00;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [7:0]  mem_data = 8'h00;
  logic        smp_valid;
  logic        smp_ready = 1'b0;
  logic [15:0] smp_data;
  logic        end_hit;

  adpcm_blk_dec u0 (.*);

  always #5 clk = ~clk;

  logic [7:0] mem [0:4095];
  int tests = 0, fails = 0;
  int nfetch = 0, lat = 0, req_cycles = 0, addr_moves = 0, hold_bad = 0;
  logic [15:0] held_addr;
  logic waiting = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // byte memory responder with varying latency
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) req_cycles++;
      if (mem_valid) begin
        mem_valid = 1'b0;
        waiting = 1'b0;
      end else if (mem_req && !start) begin
        if (waiting && mem_addr !== held_addr) addr_moves++;
        waiting = 1'b1;
        held_addr = mem_addr;
        if (lat == 0) begin
          mem_valid = 1'b1;
          mem_data = mem[mem_addr[11:0]];
          nfetch++;
          lat = nfetch % 3;
        end else lat--;
      end else waiting = 1'b0;
    end
  end

  // reference model
  logic [15:0] mptr, mloop;
  logic [7:0]  mhdr, mbyte;
  int mcnt, mhalf, mp1, mp2;
  bit mdone;

  task automatic model_start(input int idx);
    int b;
    b = 256 * dir_page + 4 * idx;
    mptr  = {mem[b+1], mem[b]};
    mloop = {mem[b+3], mem[b+2]};
    mcnt = 0; mhalf = 0; mp1 = 0; mp2 = 0; mdone = 0;
  endtask

  task automatic model_next(output int e);
    int s, r, c1, c2, v;
    logic [3:0] n;
    if (mdone) begin e = 0; return; end
    if (mhalf == 0) begin
      if (mcnt == 0) begin mhdr = mem[mptr[11:0]]; mptr++; end
      mbyte = mem[mptr[11:0]]; mptr++;
      n = mbyte[7:4];
    end else n = mbyte[3:0];
    s = (n >= 8) ? int'(n) - 16 : int'(n);
    r = mhdr[7:4];
    case (mhdr[3:2])
      2'd0: begin c1 = 0;   c2 = 0;   end
      2'd1: begin c1 = 60;  c2 = 0;   end
      2'd2: begin c1 = 122; c2 = -60; end
      default: begin c1 = 115; c2 = -52; end
    endcase
    v = s * (1 << r) + ((c1 * mp1 + c2 * mp2) >>> 6);
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    e = v; mp2 = mp1; mp1 = v;
    if (mhalf == 1) begin
      mhalf = 0; mcnt++;
      if (mcnt == 8) begin
        mcnt = 0;
        if (mhdr[0]) begin
          if (mhdr[1]) mptr = mloop; else mdone = 1;
        end
      end
    end else mhalf = 1;
  endtask

  task automatic pull(output int d, input int stall);
    logic [15:0] h;
    @(negedge clk);
    while (!smp_valid) @(negedge clk);
    h = smp_data;
    repeat (stall) begin
      @(negedge clk);
      if (!smp_valid || smp_data !== h) hold_bad++;
    end
    d = int'($signed(smp_data));
    smp_ready = 1'b1;
    @(negedge clk);
    smp_ready = 1'b0;
  endtask

  task automatic do_start(input int idx);
    @(negedge clk);
    start = 1'b1; src_idx = 8'(idx);
    @(negedge clk);
    start = 1'b0;
    chk(mem_addr == 16'(256 * dir_page + 4 * idx), "R1 directory address", mem_addr, 256 * dir_page + 4 * idx);
    chk(end_hit == 1'b0, "R12 end_hit cleared by start", end_hit, 0);
    model_start(idx);
  endtask

  task automatic run(input int n, input string tag);
    int d, e;
    for (int i = 0; i < n; i++) begin
      pull(d, i % 3);
      model_next(e);
      chk(d == e, tag, d, e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d, rc;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    mem[12'h100] = 8'h00; mem[12'h101] = 8'h02; mem[12'h102] = 8'h00; mem[12'h103] = 8'h00;
    mem[12'h104] = 8'h00; mem[12'h105] = 8'h05; mem[12'h106] = 8'h09; mem[12'h107] = 8'h05;
    mem[12'h108] = 8'h00; mem[12'h109] = 8'h06; mem[12'h10A] = 8'h00; mem[12'h10B] = 8'h00;
    for (int k = 0; k < 64; k++) begin
      mem[12'h200 + 9 * k] = {4'(k), 2'(k >> 4), 1'b0, 1'(k == 63)};
      for (int j = 0; j < 8; j++)
        mem[12'h200 + 9 * k + 1 + j] = {4'(2 * j + k), 4'(2 * j + 1 + 3 * k)};
    end
    mem[12'h500] = 8'h44;
    mem[12'h509] = 8'h6F;
    mem[12'h600] = 8'hA9;
    for (int j = 0; j < 8; j++) begin
      mem[12'h501 + j] = 8'(j * 37 + 5);
      mem[12'h50A + j] = 8'(j * 91 + 130);
      mem[12'h601 + j] = 8'(j * 53 + 71);
    end

    repeat (3) @(negedge clk);
    chk(mem_req == 1'b0 && smp_valid == 1'b0 && end_hit == 1'b0, "R11 reset state",
        {mem_req, smp_valid, end_hit}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req == 1'b0 && smp_valid == 1'b0, "R11 idle after reset", {mem_req, smp_valid}, 0);

    // sweep of every shift x filter pairing, all nibbles: R2 R3 R4 R5 R6
    do_start(0);
    run(512, "R3 R4 sweep sample");
    chk(end_hit == 1'b0, "R6 no end mid-stream", end_hit, 0);
    run(512, "R2 R6 sweep sample");
    chk(end_hit == 1'b1, "R8 end_hit after final block", end_hit, 1);
    rc = req_cycles;
    for (int i = 0; i < 4; i++) begin
      pull(d, i);
      chk(d == 0, "R8 silence after end", d, 0);
    end
    chk(req_cycles == rc, "R8 no fetch after end", req_cycles - rc, 0);
    chk(end_hit == 1'b1, "R8 end_hit sticky", end_hit, 1);

    // looping sound: R7
    do_start(1);
    run(31, "R7 loop sound sample");
    chk(end_hit == 1'b0, "R7 no end before last sample", end_hit, 0);
    run(1, "R7 loop sound sample");
    chk(end_hit == 1'b1, "R7 end_hit on looped end", end_hit, 1);
    run(48, "R7 samples after loop");

    // mid-block restart: R5 R12
    do_start(2);
    run(5, "R12 restart sample");
    do_start(2);
    run(16, "R5 history cleared on restart");
    chk(end_hit == 1'b1, "R8 one-block sound ends", end_hit, 1);
    pull(d, 1);
    chk(d == 0, "R8 silence after one-block sound", d, 0);

    chk(hold_bad == 0, "R9 output held while stalled", hold_bad, 0);
    chk(addr_moves == 0, "R10 fetch address held", addr_moves, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule